// File: doc/BRIEF.md
# Masked Sticky Error Flag Register

This block is a 64-bit control and status word that records error events from up to fifteen internal sources. Each source owns a sticky flag in the upper half of the word and an enable-inhibit (mask) bit in the lower half. Flag n sits at bit n+32 and pairs with mask bit n. A source raises its flag with a single-cycle event pulse, and only when its mask bit is 0.

Software reads the whole word in one access. A single write does two things at once. It clears the flags whose write-data bits are 1, and it reloads all fifteen mask bits. A level error output goes high while any flag is set and its mask bit is clear. Sources 11 to 14 are the four data-match comparators, 0 to 3 in that order. Sources 8 to 10 are request-match comparators 1 to 3.

The register port is a plain strobe-and-data interface. It has no valid/ready handshake and no back-pressure: a write is accepted in every cycle in which the strobe is high, and read data is always valid.

Top module: `err_flag_reg`

## Requirements
- R1: After reset the read word is all zeros and the error output is low.
- R2: An event on input n while mask bit n is 0 sets flag bit n+32. The flag is visible on the read word in the cycle after the event edge.
- R3: An event on input n while mask bit n is 1 sets no flag and does not raise the error output.
- R4: A write with data bit n+32 equal to 1 clears flag n. A write with that bit equal to 0 leaves flag n unchanged.
- R5: Every write loads mask bits 14:0 from write-data bits 14:0, and the read word returns them on those bits.
- R6: Read bits 63:47 and 31:15 are always 0, and writing 1s to them has no effect.
- R7: The error output equals the OR over n of (flag n AND NOT mask n), delayed by one register stage.
- R8: When an unmasked event arrives in the same cycle as a write that clears its flag, the flag stays set.
- R9: Setting mask bit n does not clear a flag that is already set. It only removes that flag from the error output, and clearing the mask again restores it.
- R10: Flags are sticky. A flag stays set after its event input returns low, and flags from different sources accumulate independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the register word |
| wr_data | input | 64 | Write data: bits 46:32 clear flags where set, bits 14:0 load the masks |
| rd_data | output | 64 | Current register word |
| evt_in | input | 15 | Single-cycle event pulses, one per source |
| err_o | output | 1 | Registered level error output |

## Verification
Flags and masks are registered once, so an event or a write shows on the read word in the cycle that follows its clock edge. The error output passes through one further register, so it reflects the flag and mask state one cycle after the read word does. The bench drives each stimulus before a rising edge and keeps its own reference model of the word and of the error output. At that edge it advances the model, computing the error output from the model state as it stood before the edge. It compares the read word and the error output at the next falling edge, so both results are checked against the cycle in which each is due.

// File: rtl/efr_pkg.sv
package efr_pkg;
  localparam int REG_W     = 64;
  localparam int NSRC      = 15;
  localparam int FLAG_BASE = 32;
endpackage

// File: rtl/efr_flag_cell.sv
module efr_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic mask,
  input  logic clr,
  output logic flag
);
  logic capture;
  assign capture = evt & ~mask;

  always_ff @(posedge clk) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= (flag & ~clr) | capture;
  end

  // R2 / R8: an unmasked event always leaves the flag set, even against a clear
  p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && !mask) |=> flag);
  // R3: the flag only rises through an unmasked event
  p_masked_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag && !(evt && !mask)) |=> !flag);
  // R4: a clear without a competing event drops the flag
  p_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !(evt && !mask)) |=> !flag);
  // R10: without a clear, a set flag stays set
  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);
endmodule

// File: rtl/efr_mask_bank.sv
module efr_mask_bank #(
  parameter int NSRC = efr_pkg::NSRC
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [NSRC-1:0] wr_mask,
  output logic [NSRC-1:0] mask
);
  always_ff @(posedge clk) begin
    if (!rst_n)     mask <= '0;
    else if (wr_en) mask <= wr_mask;
  end

  // R5: each write reloads the masks; otherwise they keep their value
  p_mask_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (mask == $past(wr_mask)));
  p_mask_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mask));
endmodule

// File: rtl/efr_err_reduce.sv
module efr_err_reduce #(
  parameter int NSRC = efr_pkg::NSRC
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] flag,
  input  logic [NSRC-1:0] mask,
  output logic            err
);
  logic active;
  assign active = |(flag & ~mask);

  always_ff @(posedge clk) begin
    if (!rst_n) err <= 1'b0;
    else        err <= active;
  end

  // R7 / R9: the output follows the unmasked flags one cycle later
  p_err_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag == '0) |=> !err);
  p_err_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag & ~mask) != '0) |=> err);
endmodule

// File: rtl/err_flag_reg.sv
module err_flag_reg #(
  parameter int REG_W     = efr_pkg::REG_W,
  parameter int NSRC      = efr_pkg::NSRC,
  parameter int FLAG_BASE = efr_pkg::FLAG_BASE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic [NSRC-1:0]  evt_in,
  output logic             err_o
);
  localparam int FLAG_TOP = FLAG_BASE + NSRC - 1;

  logic [NSRC-1:0] mask;
  logic [NSRC-1:0] flag;
  logic [NSRC-1:0] clr;

  assign clr = {NSRC{wr_en}} & wr_data[FLAG_TOP:FLAG_BASE];

  efr_mask_bank #(.NSRC(NSRC)) u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_mask (wr_data[NSRC-1:0]),
    .mask    (mask)
  );

  for (genvar n = 0; n < NSRC; n++) begin : g_flag
    efr_flag_cell u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .evt   (evt_in[n]),
      .mask  (mask[n]),
      .clr   (clr[n]),
      .flag  (flag[n])
    );
  end

  efr_err_reduce #(.NSRC(NSRC)) u_err (
    .clk   (clk),
    .rst_n (rst_n),
    .flag  (flag),
    .mask  (mask),
    .err   (err_o)
  );

  always_comb begin
    rd_data = '0;
    rd_data[NSRC-1:0]         = mask;
    rd_data[FLAG_TOP:FLAG_BASE] = flag;
  end

  // R6: reserved fields read back as zero
  p_rsvd_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[REG_W-1:FLAG_TOP+1] == '0) && (rd_data[FLAG_BASE-1:NSRC] == '0));
endmodule

// File: tb/test_err_flag_reg.sv
module test_err_flag_reg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [63:0] wr_data = '0;
  logic [63:0] rd_data;
  logic [14:0] evt_in = '0;
  logic        err_o;

  always #5 clk = ~clk;

  err_flag_reg i_err_flag_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .evt_in(evt_in), .err_o(err_o)
  );

  logic [14:0] flag_m = '0;
  logic [14:0] mask_m = '0;
  logic        err_m = 1'b0;

  logic [63:0] q_rd[$];
  logic        q_err[$];
  string       q_tag[$];

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;
  bit done = 0;

  function automatic logic [63:0] word(input logic [14:0] f, input logic [14:0] m);
    return {17'b0, f, 17'b0, m};
  endfunction

  task automatic step(input logic [14:0] evt, input logic we,
                      input logic [63:0] wd, input string tag);
    @(negedge clk);
    evt_in  = evt;
    wr_en   = we;
    wr_data = wd;
    @(posedge clk);
    err_m  = |(flag_m & ~mask_m);
    flag_m = (flag_m & ~({15{we}} & wd[46:32])) | (evt & ~mask_m);
    if (we) mask_m = wd[14:0];
    q_rd.push_back(word(flag_m, mask_m));
    q_err.push_back(err_m);
    q_tag.push_back(tag);
  endtask

  task automatic idle(input string tag);
    step('0, 1'b0, '0, tag);
  endtask

  always @(negedge clk) begin
    if (q_rd.size() > 0) begin
      logic [63:0] er;
      logic        ee;
      string       t;
      er = q_rd.pop_front();
      ee = q_err.pop_front();
      t  = q_tag.pop_front();
      vectors++;
      if (rd_data !== er || err_o !== ee) begin
        miscompares++;
        $display("FAIL %s: rd=%h err=%b expected rd=%h err=%b", t, rd_data, err_o, er, ee);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    // R1: reset state
    @(negedge clk);
    q_rd.push_back('0); q_err.push_back(1'b0); q_tag.push_back("R1 reset");
    @(negedge clk);
    rst_n = 1'b1;
    idle("R1 after release");
    // R2: unmasked event on source 0 sets bit 32
    step(15'h0001, 1'b0, '0, "R2 event src0");
    idle("R7 err one cycle later");
    // R10: sticky and accumulating across sources
    step(15'h4000, 1'b0, '0, "R10 accumulate src14");
    step(15'h0800, 1'b0, '0, "R10 accumulate src11");
    idle("R10 sticky hold");
    // R4: clear src0 only, write zero elsewhere leaves flags
    step('0, 1'b1, 64'h0000_0001_0000_0000, "R4 w1c src0");
    idle("R4 w0 keeps others");
    // R5: load masks
    step('0, 1'b1, 64'h0000_0000_0000_0500, "R5 mask load");
    idle("R5 mask readback");
    // R3: masked events (src8, src10) set nothing
    step(15'h0500, 1'b0, '0, "R3 masked event");
    idle("R3 no err change");
    // R9: mask flagged sources, flags stay, err drops
    step('0, 1'b1, 64'h0000_0000_0000_4800, "R9 mask flagged");
    idle("R9 err removed");
    idle("R9 err low");
    step('0, 1'b1, 64'h0000_0000_0000_0000, "R9 unmask");
    idle("R9 err restored");
    // R4: clear everything
    step('0, 1'b1, 64'h0000_7FFF_0000_0000, "R4 clear all");
    idle("R7 err falls");
    // R8: event with simultaneous clear of the same flag
    step(15'h0200, 1'b0, '0, "R8 set src9");
    step(15'h0200, 1'b1, 64'h0000_0200_0000_0000, "R8 event beats clear");
    idle("R8 flag kept");
    // R6: ones to reserved bits ignored
    step('0, 1'b1, 64'hFFFF_8000_FFFF_8000, "R6 reserved write");
    idle("R6 reserved read zero");
    step('0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, "R6 all ones write");
    idle("R6 reserved still zero");
    step(15'h7FFF, 1'b0, '0, "R3 all masked");
    step('0, 1'b1, '0, "R5 unmask all");
    step(15'h7FFF, 1'b0, '0, "R2 all sources");
    idle("R7 all err");
    idle("R10 final hold");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule